// File: doc/BRIEF.md
# Paper-Tape Reader and Punch I/O Transfer Controller

This block sits on a minicomputer backplane as a programmed-I/O slave for two emulated devices: a paper-tape reader and a paper-tape punch. Each clock it samples a single-cycle I/O transfer strobe with a 6-bit device code and a 3-bit operation field. When the code names one of its two devices, it answers in the next cycle with the internal-I/O response. Depending on the operation bits, it also returns a skip, puts reader data on the 12-bit bus together with the data-control (C1) line and the driver enable, or latches the low byte of the accumulator as a punch character. It keeps a flag and an interrupt enable for each device. The processor interrupt request follows from these in logic, with no firmware in the loop.

On the host side, an embedded processor feeds reader characters into a two-deep buffer. It reads the punch character, sets and clears either flag through separate pulses, writes both interrupt enables, and gets a one-cycle notice pulse for each reader fetch and each punch load. The reader operation bits are bit 0 skip-on-flag, bit 1 read-buffer-and-clear-flag, and bit 2 fetch (clear the flag and ask the host for a character), so operation 6 reads and fetches. The punch operation bits are bit 0 skip-on-flag, bit 1 clear-flag, and bit 2 load-and-punch.

Top module: `ptio_ctrl`

## Requirements
- R1: `internal_io` is high for exactly the one cycle after a strobe whose device code equals the reader code (default octal 01) or the punch code (default octal 02). It is low after strobes with any other code and when there is no strobe.
- R2: In the cycle after a strobe to either device with operation bit 0 set, `skip` is high if and only if that device's flag was set when the strobe was sampled.
- R3: `bus_oe` and `c1` are high only in the cycle after a reader strobe with operation bit 1 set. In that cycle `bus_data` holds the current reader character in bits 7:0 and zero in bits 11:8. Whenever `bus_oe` is low, `bus_data` is all zero.
- R4: A reader strobe with operation bit 1 set clears the reader flag.
- R5: A reader strobe with operation bit 2 set clears the reader flag and pulses `host_rdr_irq` for one cycle, in the cycle after the strobe.
- R6: A host character load is handled by buffer state. If the flag is clear and the spare slot is empty, the character becomes current and the flag sets. If the flag is set and the spare slot is empty, the character goes to the spare slot and `rdr_full` goes high. If the spare slot is already occupied, the load is ignored. Whenever the flag is clear and the spare slot is occupied, the spare character becomes current on the next edge, the flag sets and `rdr_full` falls.
- R7: A punch strobe with bit 1 set clears the punch flag. With bit 2 set, it copies `ac_data[7:0]` into `pun_char` and pulses `host_pun_irq` for one cycle, in the cycle after the strobe. Bits 11:8 of the accumulator are dropped.
- R8: `int_rq` equals, one cycle late, (reader flag AND enable bit 0) OR (punch flag AND enable bit 1). `host_ie_we` loads `host_ie_val` into the enables shown on `ie_state`.
- R9: A host set pulse sets its flag even when a host clear or a clearing strobe arrives in the same cycle. A host clear pulse alone clears it.
- R10: After synchronous reset, all flags, enables, the buffer, `pun_char` and every backplane and notice output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_strobe | input | 1 | One-cycle I/O transfer strobe |
| iot_dev | input | 6 | Device code of the transfer |
| iot_op | input | 3 | Operation bits of the transfer |
| ac_data | input | 12 | Accumulator data from the backplane |
| internal_io | output | 1 | Device-matched response |
| skip | output | 1 | Skip request |
| int_rq | output | 1 | Processor interrupt request |
| c1 | output | 1 | Data-control line for read-buffer transfers |
| bus_oe | output | 1 | Data-bus driver enable |
| bus_data | output | 12 | Data toward the accumulator |
| host_rdr_load | input | 1 | Host loads a reader character |
| host_rdr_char | input | 8 | Reader character from host |
| host_rdr_set | input | 1 | Host sets reader flag |
| host_rdr_clr | input | 1 | Host clears reader flag |
| host_pun_set | input | 1 | Host sets punch flag |
| host_pun_clr | input | 1 | Host clears punch flag |
| host_ie_we | input | 1 | Host writes interrupt enables |
| host_ie_val | input | 2 | Enables: bit 0 reader, bit 1 punch |
| rdr_flag | output | 1 | Reader flag state |
| pun_flag | output | 1 | Punch flag state |
| ie_state | output | 2 | Interrupt enable state |
| rdr_full | output | 1 | Spare reader slot occupied |
| pun_char | output | 8 | Last punched character |
| host_rdr_irq | output | 1 | Reader fetch notice to host |
| host_pun_irq | output | 1 | Punch load notice to host |

## Verification
On every cycle, the assertions tie each backplane response to the strobe sampled one cycle earlier: internal-I/O, skip, driver enable and the notice pulses. They also check the lagged interrupt equation, that the bus is all zero when the drivers are off, and that a waiting spare character is promoted. The order of characters through the two-deep reader buffer, ignored loads when the buffer is full, set-wins collisions and the byte placed on the bus can only be shown by the bench. It runs scripted character streams and host/processor races against its reference model.

// File: rtl/ptio_pkg.sv
package ptio_pkg;
  localparam int OP_W = 3;

  // Per-device decode result of one sampled strobe.
  typedef struct packed {
    logic hit;
    logic b2;
    logic b1;
    logic b0;
  } iot_sel_t;
endpackage

// File: rtl/ptio_iot_dec.sv
module ptio_iot_dec #(
  parameter int DEV_W = 6,
  parameter int NDEV  = 2,
  parameter logic [DEV_W*NDEV-1:0] CODES = {6'o02, 6'o01}
) (
  input  logic                 strobe,
  input  logic [DEV_W-1:0]     dev,
  input  logic [ptio_pkg::OP_W-1:0] op,
  output ptio_pkg::iot_sel_t   sel [NDEV]
);
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic match;
    assign match      = strobe && (dev == CODES[d*DEV_W +: DEV_W]);
    assign sel[d].hit = match;
    assign sel[d].b0  = match && op[0];
    assign sel[d].b1  = match && op[1];
    assign sel[d].b2  = match && op[2];
  end
endmodule

// File: rtl/ptio_rdr.sv
module ptio_rdr #(
  parameter int CHAR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ptio_pkg::iot_sel_t sel,
  input  logic               h_load,
  input  logic [CHAR_W-1:0]  h_char,
  input  logic               h_set,
  input  logic               h_clr,
  output logic               flag,
  output logic [CHAR_W-1:0]  cur,
  output logic               spare_v
);
  logic [CHAR_W-1:0] spare;
  logic promote, direct, to_spare, set_c, clr_c;

  always_comb begin
    promote  = !flag && spare_v;
    direct   = h_load && !flag && !spare_v;
    to_spare = h_load && flag && !spare_v;
    set_c    = h_set || promote || direct;
    clr_c    = h_clr || sel.b1 || sel.b2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      cur     <= '0;
      spare   <= '0;
      spare_v <= 1'b0;
    end else begin
      if (set_c)      flag <= 1'b1;
      else if (clr_c) flag <= 1'b0;
      if (promote)     cur <= spare;
      else if (direct) cur <= h_char;
      if (to_spare) begin
        spare   <= h_char;
        spare_v <= 1'b1;
      end else if (promote) begin
        spare_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptio_pun.sv
module ptio_pun #(
  parameter int CHAR_W = 8,
  parameter int BUS_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  ptio_pkg::iot_sel_t sel,
  input  logic [BUS_W-1:0]   ac,
  input  logic               h_set,
  input  logic               h_clr,
  output logic               flag,
  output logic [CHAR_W-1:0]  pch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      pch  <= '0;
    end else begin
      if (h_set)                  flag <= 1'b1;
      else if (h_clr || sel.b1)   flag <= 1'b0;
      if (sel.b2) pch <= ac[CHAR_W-1:0];
    end
  end
endmodule

// File: rtl/ptio_ctrl.sv
module ptio_ctrl #(
  parameter int DEV_W  = 6,
  parameter int BUS_W  = 12,
  parameter int CHAR_W = 8,
  parameter logic [DEV_W-1:0] RDR_CODE = 6'o01,
  parameter logic [DEV_W-1:0] PUN_CODE = 6'o02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iot_strobe,
  input  logic [DEV_W-1:0]  iot_dev,
  input  logic [2:0]        iot_op,
  input  logic [BUS_W-1:0]  ac_data,
  output logic              internal_io,
  output logic              skip,
  output logic              int_rq,
  output logic              c1,
  output logic              bus_oe,
  output logic [BUS_W-1:0]  bus_data,
  input  logic              host_rdr_load,
  input  logic [CHAR_W-1:0] host_rdr_char,
  input  logic              host_rdr_set,
  input  logic              host_rdr_clr,
  input  logic              host_pun_set,
  input  logic              host_pun_clr,
  input  logic              host_ie_we,
  input  logic [1:0]        host_ie_val,
  output logic              rdr_flag,
  output logic              pun_flag,
  output logic [1:0]        ie_state,
  output logic              rdr_full,
  output logic [CHAR_W-1:0] pun_char,
  output logic              host_rdr_irq,
  output logic              host_pun_irq
);
  import ptio_pkg::*;
  localparam int NDEV = 2;
  localparam int RDR  = 0;
  localparam int PUN  = 1;

  iot_sel_t          sel [NDEV];
  logic [CHAR_W-1:0] rcur;
  logic [BUS_W-1:0]  rword;

  ptio_iot_dec #(.DEV_W(DEV_W), .NDEV(NDEV), .CODES({PUN_CODE, RDR_CODE})) u_dec (
    .strobe(iot_strobe), .dev(iot_dev), .op(iot_op), .sel(sel)
  );

  ptio_rdr #(.CHAR_W(CHAR_W)) u_rdr (
    .clk(clk), .rst(rst), .sel(sel[RDR]), .h_load(host_rdr_load),
    .h_char(host_rdr_char), .h_set(host_rdr_set), .h_clr(host_rdr_clr),
    .flag(rdr_flag), .cur(rcur), .spare_v(rdr_full)
  );

  ptio_pun #(.CHAR_W(CHAR_W), .BUS_W(BUS_W)) u_pun (
    .clk(clk), .rst(rst), .sel(sel[PUN]), .ac(ac_data),
    .h_set(host_pun_set), .h_clr(host_pun_clr),
    .flag(pun_flag), .pch(pun_char)
  );

  if (BUS_W > CHAR_W) begin : g_ext
    assign rword = {{(BUS_W-CHAR_W){1'b0}}, rcur};
  end else begin : g_same
    assign rword = rcur[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      internal_io  <= 1'b0;
      skip         <= 1'b0;
      int_rq       <= 1'b0;
      c1           <= 1'b0;
      bus_oe       <= 1'b0;
      bus_data     <= '0;
      host_rdr_irq <= 1'b0;
      host_pun_irq <= 1'b0;
      ie_state     <= '0;
    end else begin
      internal_io  <= sel[RDR].hit || sel[PUN].hit;
      skip         <= (sel[RDR].b0 && rdr_flag) || (sel[PUN].b0 && pun_flag);
      int_rq       <= (rdr_flag && ie_state[0]) || (pun_flag && ie_state[1]);
      c1           <= sel[RDR].b1;
      bus_oe       <= sel[RDR].b1;
      bus_data     <= sel[RDR].b1 ? rword : '0;
      host_rdr_irq <= sel[RDR].b2;
      host_pun_irq <= sel[PUN].b2;
      if (host_ie_we) ie_state <= host_ie_val;
    end
  end
endmodule

// File: rtl/ptio_ctrl_chk.sv
module ptio_ctrl_chk #(
  parameter int DEV_W = 6,
  parameter int BUS_W = 12,
  parameter logic [DEV_W-1:0] RDR_CODE = 6'o01,
  parameter logic [DEV_W-1:0] PUN_CODE = 6'o02
) (
  input logic             clk,
  input logic             rst,
  input logic             iot_strobe,
  input logic [DEV_W-1:0] iot_dev,
  input logic [2:0]       iot_op,
  input logic             internal_io,
  input logic             skip,
  input logic             int_rq,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_data,
  input logic             rdr_flag,
  input logic             pun_flag,
  input logic [1:0]       ie_state,
  input logic             rdr_full,
  input logic             host_rdr_irq,
  input logic             host_pun_irq
);
  logic rh, ph;
  assign rh = iot_strobe && (iot_dev == RDR_CODE);
  assign ph = iot_strobe && (iot_dev == PUN_CODE);

  // R1
  iio_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (internal_io == $past(rh || ph)));
  // R2
  skip_src_chk: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past((rh && iot_op[0] && rdr_flag) || (ph && iot_op[0] && pun_flag)));
  // R3
  oe_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(rh && iot_op[1]));
  // R3
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0));
  // R5
  rirq_src_chk: assert property (@(posedge clk) disable iff (rst)
    host_rdr_irq |-> $past(rh && iot_op[2]));
  // R6
  promote_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdr_flag && rdr_full) |=> (rdr_flag && !rdr_full));
  // R7
  pirq_src_chk: assert property (@(posedge clk) disable iff (rst)
    host_pun_irq |-> $past(ph && iot_op[2]));
  // R8
  intrq_eq_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int_rq == $past((rdr_flag && ie_state[0]) || (pun_flag && ie_state[1]))));
endmodule

bind ptio_ctrl ptio_ctrl_chk #(.DEV_W(DEV_W), .BUS_W(BUS_W), .RDR_CODE(RDR_CODE), .PUN_CODE(PUN_CODE)) u_chk (
  .clk(clk), .rst(rst), .iot_strobe(iot_strobe), .iot_dev(iot_dev), .iot_op(iot_op),
  .internal_io(internal_io), .skip(skip), .int_rq(int_rq), .bus_oe(bus_oe),
  .bus_data(bus_data), .rdr_flag(rdr_flag), .pun_flag(pun_flag), .ie_state(ie_state),
  .rdr_full(rdr_full), .host_rdr_irq(host_rdr_irq), .host_pun_irq(host_pun_irq)
);

// File: tb/sim_ptio_ctrl.sv
module sim_ptio_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic iot_strobe = 0;
  logic [5:0] iot_dev = 0;
  logic [2:0] iot_op = 0;
  logic [11:0] ac_data = 0;
  logic internal_io, skip, int_rq, c1, bus_oe;
  logic [11:0] bus_data;
  logic host_rdr_load = 0;
  logic [7:0] host_rdr_char = 0;
  logic host_rdr_set = 0, host_rdr_clr = 0, host_pun_set = 0, host_pun_clr = 0;
  logic host_ie_we = 0;
  logic [1:0] host_ie_val = 0;
  logic rdr_flag, pun_flag, rdr_full, host_rdr_irq, host_pun_irq;
  logic [1:0] ie_state;
  logic [7:0] pun_char;

  always #2.5 clk = ~clk;

  ptio_ctrl u0 (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // Reference model state
  bit m_rf, m_pf, m_iio, m_skip, m_oe, m_int, m_rirq, m_pirq;
  bit [1:0] m_ie;
  bit [7:0] m_cur, m_pch;
  bit [11:0] m_bus;
  byte unsigned m_q[$];

  task automatic cmp(string req, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rf = 0; m_pf = 0; m_iio = 0; m_skip = 0; m_oe = 0; m_int = 0;
    m_rirq = 0; m_pirq = 0; m_ie = 0; m_cur = 0; m_pch = 0; m_bus = 0;
    m_q.delete();
  endtask

  task automatic model_step();
    bit rh, ph, rset, rclr, n_rf;
    rh = iot_strobe && iot_dev == 6'o01;
    ph = iot_strobe && iot_dev == 6'o02;
    m_iio  = rh || ph;
    m_skip = (rh && iot_op[0] && m_rf) || (ph && iot_op[0] && m_pf);
    m_oe   = rh && iot_op[1];
    m_bus  = m_oe ? {4'h0, m_cur} : 12'h0;
    m_int  = (m_rf && m_ie[0]) || (m_pf && m_ie[1]);
    m_rirq = rh && iot_op[2];
    m_pirq = ph && iot_op[2];
    // reader buffer: current char + waiting queue of at most one
    rset = host_rdr_set;
    rclr = host_rdr_clr || (rh && (iot_op[1] || iot_op[2]));
    if (!m_rf && m_q.size() > 0) begin
      m_cur = m_q.pop_front();
      rset = 1;
    end else if (host_rdr_load && m_q.size() == 0) begin
      if (!m_rf) begin m_cur = host_rdr_char; rset = 1; end
      else m_q.push_back(host_rdr_char);
    end
    n_rf = rset ? 1'b1 : (rclr ? 1'b0 : m_rf);
    m_rf = n_rf;
    if (host_pun_set) m_pf = 1;
    else if (host_pun_clr || (ph && iot_op[1])) m_pf = 0;
    if (ph && iot_op[2]) m_pch = ac_data[7:0];
    if (host_ie_we) m_ie = host_ie_val;
  endtask

  task automatic compare_all();
    cmp("R1", "internal_io", internal_io, m_iio);
    cmp("R2", "skip", skip, m_skip);
    cmp("R3", "bus_oe", bus_oe, m_oe);
    cmp("R3", "c1", c1, m_oe);
    cmp("R3", "bus_data", bus_data, m_bus);
    cmp("R4/R6/R9", "rdr_flag", rdr_flag, m_rf);
    cmp("R5", "host_rdr_irq", host_rdr_irq, m_rirq);
    cmp("R6", "rdr_full", rdr_full, m_q.size() != 0);
    cmp("R7", "pun_char", pun_char, m_pch);
    cmp("R7", "host_pun_irq", host_pun_irq, m_pirq);
    cmp("R7/R9", "pun_flag", pun_flag, m_pf);
    cmp("R8", "int_rq", int_rq, m_int);
    cmp("R8", "ie_state", ie_state, m_ie);
  endtask

  // one clock with the currently driven inputs, then clear pulses
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    iot_strobe = 0; host_rdr_load = 0; host_rdr_set = 0; host_rdr_clr = 0;
    host_pun_set = 0; host_pun_clr = 0; host_ie_we = 0;
  endtask

  task automatic iot(input logic [5:0] d, input logic [2:0] o);
    iot_strobe = 1; iot_dev = d; iot_op = o; step();
  endtask

  task automatic load(input byte unsigned c);
    host_rdr_load = 1; host_rdr_char = c; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    cmp("R10", "rdr_flag", rdr_flag, 0);
    cmp("R10", "pun_flag", pun_flag, 0);
    cmp("R10", "bus_oe", bus_oe, 0);
    cmp("R10", "int_rq", int_rq, 0);
    cmp("R10", "rdr_full", rdr_full, 0);
    cmp("R10", "pun_char", pun_char, 0);
    idle(2);
    host_ie_we = 1; host_ie_val = 2'b01; step();        // R8
    iot(6'o03, 3'd7); iot(6'o41, 3'd2);                  // R1 foreign codes
    iot(6'o01, 3'd1);                                    // R2 skip, flag clear
    load(8'h41); load(8'h42); load(8'h43);               // R6 direct, spare, ignored
    idle(1);
    iot(6'o01, 3'd1);                                    // R2 skip with flag set
    iot(6'o01, 3'd6);                                    // R3 R5 read+fetch 41
    idle(2);                                             // R6 promote 42
    iot(6'o01, 3'd2);                                    // R4 read 42
    iot(6'o01, 3'd4);                                    // R5 fetch, empty buffer
    idle(1);
    for (int i = 0; i < 8; i++) begin                    // stream of characters
      load(8'(8'h80 + i * 17));
      if (i % 2 == 0) load(8'(8'h10 + i));
      iot(6'o01, 3'd1);
      iot(6'o01, 3'd6);
      idle(i % 3);
    end
    idle(2);
    while (rdr_flag) begin iot(6'o01, 3'd6); idle(1); end
    // R9 collisions
    host_rdr_set = 1; host_rdr_clr = 1; step();
    host_rdr_set = 1; iot_strobe = 1; iot_dev = 6'o01; iot_op = 3'd2; step();
    host_rdr_clr = 1; step();
    // R7 punch
    host_ie_we = 1; host_ie_val = 2'b11; step();
    iot(6'o02, 3'd1);
    ac_data = 12'hA5C; iot(6'o02, 3'd4);
    host_pun_set = 1; step();
    iot(6'o02, 3'd1);
    ac_data = 12'h3E7; iot(6'o02, 3'd6);
    host_pun_set = 1; step();
    host_pun_set = 1; host_pun_clr = 1; step();
    iot(6'o02, 3'd2);
    host_pun_set = 1; iot_strobe = 1; iot_dev = 6'o02; iot_op = 3'd2; step();
    host_ie_we = 1; host_ie_val = 2'b00; step();
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule